// File: doc/BRIEF.md
# Loop Branch Target Cache

This fetch-side unit keeps the instruction stream flowing across the backward branch that closes a loop. It fetches 16-bit instruction words in order from a synchronous code memory and delivers one word per cycle on an output stream. The unit holds a single remembered branch: its word address, its target, and the instruction word found at that target. A branch unit reports each resolved branch while the branch word is on the output.

When a reported taken branch matches the remembered one, the stored target word goes out in the very next cycle, and fetch resumes two bytes past the target. The only cost is the branch's own cycle. A taken branch that does not match triggers a refill. The unit drops the word already in flight, fetches the target, writes it into the entry and only then resumes.

Loops need no special instruction. A loop of any length therefore loses exactly two output cycles on its first loop-back and none on later ones. Leaving the loop by a not-taken branch loses none. Flushing, for example on interrupt entry or a write to code memory, forgets the entry.

Top module: `loop_branch_cache`

## Requirements
- R1: While `rst` is high, `out_valid` is low, `mem_rd` is high and `mem_addr` equals `RESET_PC`. The word at `RESET_PC` appears on the output in the first cycle after `rst` falls.
- R2: Memory protocol: a read issued with `mem_rd` and `mem_addr` in cycle c returns data on `mem_rdata` in cycle c+1. Each valid output carries a byte address in `out_pc` and the memory word at that address in `out_instr`. Without a taken branch, each valid output follows the previous one at `out_pc`+2.
- R3: A not-taken branch report loses no cycle. The next cycle outputs the word at branch address + 2.
- R4: A taken branch whose address does not match the valid entry gives exactly two cycles with `out_valid` low. The target word follows in the third cycle, and the entry is then replaced by this branch.
- R5: A taken branch whose address matches the valid entry outputs the target word in the next cycle. Sequential words from target+2 follow with no gap.
- R6: A loop run for N iterations (N-1 taken closings, then one not-taken exit) loses exactly two output cycles in total when N is at least 2, and none when N is 1.
- R7: A cycle with `flush` high invalidates the entry. The next taken branch, even to the same address, pays the full two-cycle refill.
- R8: Branch reports in cycles with `out_valid` low are ignored. The output stream is unchanged.
- R9: Bit 0 of `br_pc` and `br_target` is ignored. `mem_addr` bit 0 is always 0 while `mem_rd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate the remembered branch |
| br_valid | input | 1 | A branch is resolved for the word on the output this cycle |
| br_taken | input | 1 | The resolved branch is taken |
| br_pc | input | AW | Byte address of the branch word |
| br_target | input | AW | Byte address of the branch target |
| mem_rd | output | 1 | Code memory read request |
| mem_addr | output | AW | Byte address of the read |
| mem_rdata | input | DW | Word read, one cycle after the request |
| out_valid | output | 1 | An instruction word is presented this cycle |
| out_pc | output | AW | Byte address of the presented word |
| out_instr | output | DW | Presented instruction word |

## Verification
A corrupted entry or a wrong match shows up at the ports as a wrong gap pattern. A hit that should have been a miss delivers a stale target word in the very next cycle. A miss that should have been a hit opens two idle cycles where none were expected. A wrong fetch address or a lost squash of the in-flight word shows up as an `out_pc` or `out_instr` mismatch at once, one cycle after the faulty request. The bench therefore follows the expected address of every output word, and it counts idle cycles per loop against the refill budget of that loop.

// File: rtl/lbc_pkg.sv
package lbc_pkg;

    typedef enum logic [1:0] {
        FS_RUN   = 2'd0,
        FS_MREQ  = 2'd1,
        FS_MWAIT = 2'd2
    } fetch_state_e;

    localparam int LBC_ADDR_W = 16;
    localparam int LBC_DATA_W = 16;

    function automatic logic [LBC_ADDR_W-2:0] lbc_succ(input logic [LBC_ADDR_W-2:0] wpc);
        return wpc + (LBC_ADDR_W-1)'(1);
    endfunction

endpackage

// File: rtl/lbc_entry.sv
module lbc_entry #(
    parameter int WAW = 15,
    parameter int DW  = 16
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           flush,
    input  logic [WAW-1:0] lk_wpc,
    output logic           lk_hit,
    input  logic           wr_en,
    input  logic [WAW-1:0] wr_wpc,
    input  logic [WAW-1:0] wr_wtgt,
    input  logic [DW-1:0]  wr_word,
    output logic [WAW-1:0] rd_wtgt,
    output logic [DW-1:0]  rd_word
);
    logic           ent_v;
    logic [WAW-1:0] ent_wpc;
    logic [WAW-1:0] ent_wtgt;
    logic [DW-1:0]  ent_word;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            ent_v <= 1'b0;
        end else if (wr_en) begin
            ent_v <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_wpc  <= '0;
            ent_wtgt <= '0;
            ent_word <= '0;
        end else if (wr_en) begin
            ent_wpc  <= wr_wpc;
            ent_wtgt <= wr_wtgt;
            ent_word <= wr_word;
        end
    end

    assign lk_hit  = ent_v && !flush && (ent_wpc == lk_wpc);
    assign rd_wtgt = ent_wtgt;
    assign rd_word = ent_word;
endmodule

// File: rtl/lbc_fetch.sv
module lbc_fetch
    import lbc_pkg::*;
#(
    parameter int             WAW       = 15,
    parameter int             DW        = 16,
    parameter logic [WAW-1:0] RESET_WPC = '0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           redirect,
    input  logic           hit,
    input  logic [WAW-1:0] br_wpc,
    input  logic [WAW-1:0] br_wtgt,
    input  logic [WAW-1:0] ent_wtgt,
    input  logic [DW-1:0]  ent_word,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_rd,
    output logic [WAW-1:0] mem_wpc,
    output logic           pend_v,
    output logic [WAW-1:0] pend_wpc,
    output logic           inj_v,
    output logic [WAW-1:0] inj_wpc,
    output logic [DW-1:0]  inj_word,
    output logic           wr_en,
    output logic [WAW-1:0] wr_wpc,
    output logic [WAW-1:0] wr_wtgt,
    output logic [DW-1:0]  wr_word
);
    fetch_state_e   st;
    logic [WAW-1:0] fpc;
    logic [WAW-1:0] rf_wpc;
    logic [WAW-1:0] rf_wtgt;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= FS_RUN;
            fpc      <= RESET_WPC;
            pend_v   <= 1'b0;
            pend_wpc <= '0;
            inj_v    <= 1'b0;
            inj_wpc  <= '0;
            inj_word <= '0;
            rf_wpc   <= '0;
            rf_wtgt  <= '0;
        end else begin
            case (st)
                FS_RUN: begin
                    if (redirect && hit) begin
                        inj_v    <= 1'b1;
                        inj_wpc  <= ent_wtgt;
                        inj_word <= ent_word;
                        pend_v   <= 1'b0;
                        fpc      <= lbc_succ(ent_wtgt);
                    end else if (redirect) begin
                        st      <= FS_MREQ;
                        fpc     <= br_wtgt;
                        rf_wpc  <= br_wpc;
                        rf_wtgt <= br_wtgt;
                        pend_v  <= 1'b0;
                        inj_v   <= 1'b0;
                    end else begin
                        pend_v   <= 1'b1;
                        pend_wpc <= fpc;
                        fpc      <= lbc_succ(fpc);
                        inj_v    <= 1'b0;
                    end
                end
                FS_MREQ: begin
                    st     <= FS_MWAIT;
                    pend_v <= 1'b0;
                    inj_v  <= 1'b0;
                end
                FS_MWAIT: begin
                    st       <= FS_RUN;
                    inj_v    <= 1'b1;
                    inj_wpc  <= rf_wtgt;
                    inj_word <= mem_rdata;
                    fpc      <= lbc_succ(rf_wtgt);
                end
                default: begin
                    st <= FS_RUN;
                end
            endcase
        end
    end

    assign mem_rd  = (st != FS_MWAIT);
    assign mem_wpc = fpc;
    assign wr_en   = (st == FS_MWAIT);
    assign wr_wpc  = rf_wpc;
    assign wr_wtgt = rf_wtgt;
    assign wr_word = mem_rdata;
endmodule

// File: rtl/lbc_out_sel.sv
module lbc_out_sel #(
    parameter int WAW = 15,
    parameter int DW  = 16
) (
    input  logic           pend_v,
    input  logic [WAW-1:0] pend_wpc,
    input  logic [DW-1:0]  mem_rdata,
    input  logic           inj_v,
    input  logic [WAW-1:0] inj_wpc,
    input  logic [DW-1:0]  inj_word,
    output logic           o_valid,
    output logic [WAW-1:0] o_wpc,
    output logic [DW-1:0]  o_word
);
    always_comb begin
        o_valid = inj_v || pend_v;
        if (inj_v) begin
            o_wpc  = inj_wpc;
            o_word = inj_word;
        end else begin
            o_wpc  = pend_wpc;
            o_word = mem_rdata;
        end
    end
endmodule

// File: rtl/loop_branch_cache.sv
module loop_branch_cache
    import lbc_pkg::*;
#(
    parameter int            AW       = LBC_ADDR_W,
    parameter int            DW       = LBC_DATA_W,
    parameter logic [AW-1:0] RESET_PC = 16'h0100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          br_valid,
    input  logic          br_taken,
    input  logic [AW-1:0] br_pc,
    input  logic [AW-1:0] br_target,
    output logic          mem_rd,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic          out_valid,
    output logic [AW-1:0] out_pc,
    output logic [DW-1:0] out_instr
);
    localparam int             WAW       = AW - 1;
    localparam logic [WAW-1:0] RESET_WPC = RESET_PC[AW-1:1];

    logic           redirect;
    logic           ent_hit;
    logic [WAW-1:0] ent_wtgt;
    logic [DW-1:0]  ent_word;
    logic           wr_en;
    logic [WAW-1:0] wr_wpc;
    logic [WAW-1:0] wr_wtgt;
    logic [DW-1:0]  wr_word;
    logic [WAW-1:0] mem_wpc;
    logic           pend_v;
    logic [WAW-1:0] pend_wpc;
    logic           inj_v;
    logic [WAW-1:0] inj_wpc;
    logic [DW-1:0]  inj_word;
    logic [WAW-1:0] o_wpc;
    logic           unused_lsb;

    assign redirect   = br_valid && br_taken && out_valid;
    assign unused_lsb = br_pc[0] ^ br_target[0];

    lbc_entry #(.WAW(WAW), .DW(DW)) u_entry (
        .clk     (clk),
        .rst     (rst),
        .flush   (flush),
        .lk_wpc  (br_pc[AW-1:1]),
        .lk_hit  (ent_hit),
        .wr_en   (wr_en),
        .wr_wpc  (wr_wpc),
        .wr_wtgt (wr_wtgt),
        .wr_word (wr_word),
        .rd_wtgt (ent_wtgt),
        .rd_word (ent_word)
    );

    lbc_fetch #(.WAW(WAW), .DW(DW), .RESET_WPC(RESET_WPC)) u_fetch (
        .clk       (clk),
        .rst       (rst),
        .redirect  (redirect),
        .hit       (ent_hit),
        .br_wpc    (br_pc[AW-1:1]),
        .br_wtgt   (br_target[AW-1:1]),
        .ent_wtgt  (ent_wtgt),
        .ent_word  (ent_word),
        .mem_rdata (mem_rdata),
        .mem_rd    (mem_rd),
        .mem_wpc   (mem_wpc),
        .pend_v    (pend_v),
        .pend_wpc  (pend_wpc),
        .inj_v     (inj_v),
        .inj_wpc   (inj_wpc),
        .inj_word  (inj_word),
        .wr_en     (wr_en),
        .wr_wpc    (wr_wpc),
        .wr_wtgt   (wr_wtgt),
        .wr_word   (wr_word)
    );

    lbc_out_sel #(.WAW(WAW), .DW(DW)) u_out (
        .pend_v    (pend_v),
        .pend_wpc  (pend_wpc),
        .mem_rdata (mem_rdata),
        .inj_v     (inj_v),
        .inj_wpc   (inj_wpc),
        .inj_word  (inj_word),
        .o_valid   (out_valid),
        .o_wpc     (o_wpc),
        .o_word    (out_instr)
    );

    assign mem_addr = {mem_wpc, 1'b0};
    assign out_pc   = {o_wpc, 1'b0};
endmodule

// File: rtl/lbc_checker.sv
module lbc_checker #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          flush,
    input logic          br_valid,
    input logic          br_taken,
    input logic          out_valid,
    input logic [AW-1:0] out_pc,
    input logic          ent_hit
);
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !br_valid) |=> (!out_valid || out_pc == $past(out_pc) + AW'(2))); // R2

    AST_FALLTHRU_FREE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && br_valid && !br_taken) |=> (out_valid && out_pc == $past(out_pc) + AW'(2))); // R3

    AST_MISS_TWO_GAPS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && br_valid && br_taken && !ent_hit) |=> !out_valid ##1 !out_valid ##1 out_valid); // R4

    AST_HIT_NO_GAP: assert property (@(posedge clk) disable iff (rst)
        (out_valid && br_valid && br_taken && ent_hit) |=> out_valid); // R5

    AST_FLUSH_FORGETS: assert property (@(posedge clk) disable iff (rst)
        flush |=> !ent_hit); // R7
endmodule

bind loop_branch_cache lbc_checker #(.AW(AW)) u_lbc_checker (
    .clk       (clk),
    .rst       (rst),
    .flush     (flush),
    .br_valid  (br_valid),
    .br_taken  (br_taken),
    .out_valid (out_valid),
    .out_pc    (out_pc),
    .ent_hit   (ent_hit)
);

// File: tb/test_loop_branch_cache.sv
`timescale 1ns/1ps
module test_loop_branch_cache;
    localparam logic [15:0] RST_PC = 16'h0100;
    localparam int          NL     = 7;
    // {body length in words, iterations, flush in iteration 3, expected gap cycles}
    localparam logic [31:0] LOOPS [NL] = '{
        {8'd6, 8'd5,  8'd0, 8'd2},
        {8'd3, 8'd1,  8'd0, 8'd0},
        {8'd4, 8'd2,  8'd0, 8'd2},
        {8'd1, 8'd8,  8'd0, 8'd2},
        {8'd5, 8'd10, 8'd0, 8'd2},
        {8'd4, 8'd6,  8'd1, 8'd4},
        {8'd2, 8'd3,  8'd0, 8'd2}
    };

    logic        clk = 1'b0;
    logic        rst, flush, br_valid, br_taken;
    logic [15:0] br_pc, br_target;
    logic        mem_rd;
    logic [15:0] mem_addr, mem_rdata;
    logic        out_valid;
    logic [15:0] out_pc, out_instr;

    int errs = 0, checks = 0, stream_errs = 0, spurious = 0, odd_addr = 0;

    always #10 clk = ~clk;

    function automatic logic [15:0] mfun(input logic [15:0] a);
        return (a * 16'd3) ^ 16'h5A3C;
    endfunction

    always @(posedge clk) if (mem_rd) mem_rdata <= mfun(mem_addr);

    loop_branch_cache #(.RESET_PC(RST_PC)) i_loop_branch_cache (
        .clk(clk), .rst(rst), .flush(flush), .br_valid(br_valid), .br_taken(br_taken),
        .br_pc(br_pc), .br_target(br_target), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .out_valid(out_valid), .out_pc(out_pc), .out_instr(out_instr)
    );

    task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        errs++; checks++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [15:0] s, b, exp_pc, len, iters;
        int          k, it, gaps, e0;
        bit          flushed;
        string       ctx;
        rst = 1'b1; flush = 1'b0; br_valid = 1'b0; br_taken = 1'b0;
        br_pc = '0; br_target = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle in reset", {15'd0, out_valid}, 16'd0);
        chk(mem_rd == 1'b1 && mem_addr == RST_PC, "R1 reset fetch address", mem_addr, RST_PC);
        rst = 1'b0;

        k = 0; s = RST_PC; it = 1; gaps = 0; exp_pc = RST_PC; ctx = "R1"; flushed = 1'b0;
        while (k < NL) begin
            @(negedge clk);
            br_valid = 1'b0; br_taken = 1'b0; flush = 1'b0;
            len   = 16'(LOOPS[k][31:24]);
            iters = 16'(LOOPS[k][23:16]);
            b     = s + 16'd2 * (len - 16'd1);
            if (mem_rd && mem_addr[0]) odd_addr++;
            if (!out_valid) begin
                // R8: a taken report naming the loop branch while idle must be ignored
                gaps++; spurious++;
                br_valid = 1'b1; br_taken = 1'b1; br_pc = b; br_target = 16'h3F00;
            end else begin
                e0 = errs;
                chk(out_pc == exp_pc, {ctx, " address"}, out_pc, exp_pc);
                chk(out_instr == mfun(exp_pc), {ctx, " word"}, out_instr, mfun(exp_pc));
                if (errs != e0) stream_errs++;
                if (LOOPS[k][15:8] != 0 && it == 3 && out_pc == s && len > 1) begin
                    flush = 1'b1; flushed = 1'b1;
                end
                if (out_pc == b) begin
                    br_valid = 1'b1; br_pc = b | 16'h0001; br_target = s | 16'h0001; // R9 odd bits
                    if (16'(it) < iters) begin
                        br_taken = 1'b1;
                        ctx = (it == 1 || flushed) ? "R4 refill target" : "R5 hit target";
                        it++; exp_pc = s; flushed = 1'b0;
                    end else begin
                        if (LOOPS[k][15:8] != 0)
                            chk(gaps == int'(LOOPS[k][7:0]), "R7 gaps with flush", 16'(gaps), 16'(LOOPS[k][7:0]));
                        else
                            chk(gaps == int'(LOOPS[k][7:0]), "R6 gaps per loop", 16'(gaps), 16'(LOOPS[k][7:0]));
                        k++; s = b + 16'd2; it = 1; gaps = 0; exp_pc = b + 16'd2; ctx = "R3 fall-through";
                    end
                end else begin
                    exp_pc = exp_pc + 16'd2;
                    if (ctx != "R1") ctx = "R2 sequential";
                    else ctx = "R2 sequential";
                end
            end
        end
        @(negedge clk);
        br_valid = 1'b0; br_taken = 1'b0;
        chk(spurious > 0 && stream_errs == 0, "R8 idle reports ignored", 16'(stream_errs), 16'd0);
        chk(odd_addr == 0, "R9 even fetch addresses", 16'(odd_addr), 16'd0);

        // directed: reset in mid-stream
        rst = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 idle after mid-stream reset", {15'd0, out_valid}, 16'd0);
        chk(mem_addr == RST_PC, "R1 restart address", mem_addr, RST_PC);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid && out_pc == RST_PC, "R1 first word after reset", out_pc, RST_PC);
        chk(out_instr == mfun(RST_PC), "R1 first word data", out_instr, mfun(RST_PC));
        @(negedge clk);
        chk(out_valid && out_pc == RST_PC + 16'd2, "R2 step after reset", out_pc, RST_PC + 16'd2);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule